// File: doc/BRIEF.md
# 8 kHz Frame Sync Generator

This block builds a once-per-frame timing mark from the fast output clock, so that the mark stays locked to the clocks the device sends out. A free-running divider counts `FRAME_LEN` cycles of `clk` per frame. For example, 19440 cycles of a 155.52 MHz clock give 8 kHz. A registered shaper turns the divider count into the output waveform. The waveform is either a square wave with a 50:50 duty cycle or one short pulse per frame. The pulse can sit where the square wave would rise or where it would fall. The pulse lasts `PULSE_LEN` fast cycles, which is one period of the slower secondary output clock.

Downstream logic may want the frame phase to follow an external frame reference. When realignment is permitted, a falling transition of the selected external sync reloads the divider to zero. Only the frame in which that happens is shortened or stretched. The output can be gated off, in which case the divider keeps running, and its final polarity can be inverted. Selecting the external sync and monitoring it for alarms are done outside this block.

Top module: `frame_sync_gen`

## Requirements
- R1: While `rst_n` is low, `fs_out` is 0 and the divider count is 0.
- R2: With no realignment, the divider counts 0 to `FRAME_LEN`-1 and wraps to 0, so the frame period is exactly `FRAME_LEN` cycles. `fs_out` is registered: after the clock edge at which the count is c, it shows the waveform value for count c.
- R3: In square mode (`pulse_mode`=0), the waveform is high for counts 0 to `FRAME_LEN`/2-1 and low for all other counts.
- R4: In pulse mode with `pulse_at_fall`=0, the waveform is high only for counts 0 to `PULSE_LEN`-1.
- R5: In pulse mode with `pulse_at_fall`=1, the waveform is high only for counts `FRAME_LEN`/2 to `FRAME_LEN`/2+`PULSE_LEN`-1.
- R6: When `invert`=1, `fs_out` is the complement of the waveform value. When `invert`=0, `fs_out` is the waveform value itself.
- R7: When `en`=0, the waveform value is 0, so `fs_out` equals `invert`. The divider keeps counting, so the frame phase seen after re-enabling is unchanged.
- R8: With `resync_en`=1, suppose `ext_sync` is sampled 1 at one clock edge and 0 at the next. At that second edge the count loads 0 instead of advancing. The `ext_sync` sample register resets to 0.
- R9: With `resync_en`=0, `ext_sync` has no effect on the frame phase.
- R10: A rising transition or a steady level of `ext_sync` never changes the frame phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast output-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Output enable |
| invert | input | 1 | Final polarity inversion |
| pulse_mode | input | 1 | 0 = square wave, 1 = one pulse per frame |
| pulse_at_fall | input | 1 | Pulse position: 0 = square-wave rising point, 1 = falling point |
| resync_en | input | 1 | Permits realignment to `ext_sync` |
| ext_sync | input | 1 | Selected external frame sync, already synchronized to `clk` |
| fs_out | output | 1 | Frame sync output |

## Verification
The bench runs every combination of enable, inversion, shape and pulse position over whole frames. A wrong half-point or pulse window shows up as a duty error or a pulse shifted by whole cycles. An off-by-one in the wrap shows up as a frame period that drifts by a cycle each frame. The bench also drops `ext_sync` at every count of the frame. A divider that reloads one cycle late, or that ignores a fall at the wrap boundary, leaves the output shifted by one count. A design that honours the fall while realignment is forbidden, or that reacts to rising edges, moves the phase when it should stay fixed. Toggling `en` mid-frame exposes a divider that pauses while the output is gated.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic {
    SHAPE_SQUARE = 1'b0,
    SHAPE_PULSE  = 1'b1
  } shape_e;

  typedef enum logic {
    POS_RISE = 1'b0,
    POS_FALL = 1'b1
  } pos_e;
endpackage

// File: rtl/fs_edge_detect.sv
module fs_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic arm,
  output logic realign
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d  = sync_in;
    realign = arm & prev_q & ~sync_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/fs_divider.sv
module fs_divider #(
  parameter int FRAME_LEN = 19440,
  parameter int CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             realign,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (realign)             cnt_d = '0;
    else if (cnt_q == LAST)  cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/fs_shaper.sv
module fs_shaper
  import fs_pkg::*;
#(
  parameter int FRAME_LEN = 19440,
  parameter int PULSE_LEN = 8,
  parameter int CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             en,
  input  logic             invert,
  input  shape_e           shape,
  input  pos_e             pos,
  output logic             fs_out
);
  localparam int HALF_I = FRAME_LEN / 2;
  localparam logic [CNT_W-1:0] HALF_C      = CNT_W'(HALF_I);
  localparam logic [CNT_W-1:0] PULSE_C     = CNT_W'(PULSE_LEN);
  localparam logic [CNT_W-1:0] FALL_END_C  = CNT_W'(HALF_I + PULSE_LEN);

  logic square_w;
  logic pulse_w;
  logic wave_w;
  logic out_d;
  logic out_q;

  always_comb begin
    square_w = (cnt < HALF_C);
    if (pos == POS_FALL) pulse_w = (cnt >= HALF_C) && (cnt < FALL_END_C);
    else                 pulse_w = (cnt < PULSE_C);
    wave_w = en & ((shape == SHAPE_PULSE) ? pulse_w : square_w);
    out_d  = wave_w ^ invert;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign fs_out = out_q;
endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
  import fs_pkg::*;
#(
  parameter int FRAME_LEN = 19440,
  parameter int PULSE_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic invert,
  input  logic pulse_mode,
  input  logic pulse_at_fall,
  input  logic resync_en,
  input  logic ext_sync,
  output logic fs_out
);
  localparam int CNT_W = $clog2(FRAME_LEN);

  logic             realign;
  logic [CNT_W-1:0] cnt;
  shape_e           shape;
  pos_e             pos;

  assign shape = shape_e'(pulse_mode);
  assign pos   = pos_e'(pulse_at_fall);

  fs_edge_detect u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_in (ext_sync),
    .arm     (resync_en),
    .realign (realign)
  );

  fs_divider #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .realign (realign),
    .cnt     (cnt)
  );

  fs_shaper #(.FRAME_LEN(FRAME_LEN), .PULSE_LEN(PULSE_LEN), .CNT_W(CNT_W)) u_shape (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt    (cnt),
    .en     (en),
    .invert (invert),
    .shape  (shape),
    .pos    (pos),
    .fs_out (fs_out)
  );
endmodule

// File: rtl/fs_sync_checker.sv
module fs_sync_checker #(
  parameter int FRAME_LEN = 19440,
  parameter int CNT_W     = $clog2(FRAME_LEN)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             invert,
  input logic             realign,
  input logic [CNT_W-1:0] cnt,
  input logic             fs_out
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == LAST && !realign) |=> cnt == '0);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != LAST && !realign) |=> cnt == $past(cnt) + 1'b1);

  p_realign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> cnt == '0);

  p_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> fs_out == $past(invert));
endmodule

bind frame_sync_gen fs_sync_checker #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .invert  (invert),
  .realign (realign),
  .cnt     (cnt),
  .fs_out  (fs_out)
);

// File: tb/tb_frame_sync_gen.sv
module tb_frame_sync_gen;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 24;
  localparam int PL  = 3;
  localparam int H   = N / 2;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, invert = 1'b0, pulse_mode = 1'b0, pulse_at_fall = 1'b0;
  logic resync_en = 1'b0, ext_sync = 1'b0;
  logic fs_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  string phase_tag = "R1";

  int ref_cnt  = 0;
  bit ref_prev = 1'b0;
  bit exp_out  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_sync_gen #(.FRAME_LEN(N), .PULSE_LEN(PL)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .invert(invert),
    .pulse_mode(pulse_mode), .pulse_at_fall(pulse_at_fall),
    .resync_en(resync_en), .ext_sync(ext_sync), .fs_out(fs_out)
  );

  function automatic bit wave(int c);
    bit w;
    if (!pulse_mode)        w = (c < H);
    else if (pulse_at_fall) w = (c >= H) && (c < H + PL);
    else                    w = (c < PL);
    return en && w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt  <= 0;
      ref_prev <= 1'b0;
      exp_out  <= 1'b0;
    end else begin
      exp_out  <= wave(ref_cnt) ^ invert;
      ref_prev <= ext_sync;
      if (resync_en && ref_prev && !ext_sync) ref_cnt <= 0;
      else                                    ref_cnt <= (ref_cnt == N-1) ? 0 : ref_cnt + 1;
    end
  end

  task automatic check(string tag);
    checks++;
    if (fs_out !== exp_out) begin
      fails++;
      $display("FAIL %s: fs_out=%0b expected %0b (cfg en=%0b inv=%0b pm=%0b pf=%0b)",
               tag, fs_out, exp_out, en, invert, pulse_mode, pulse_at_fall);
    end
  endtask

  task automatic step_check(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(phase_tag);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected < %0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (fs_out !== 1'b0) begin
      fails++;
      $display("FAIL R1: fs_out=%0b expected 0", fs_out);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R6 R7: every configuration over two full frames
    for (int cfg = 0; cfg < 16; cfg++) begin
      @(negedge clk);
      check("R2 config change");
      en = cfg[0]; invert = cfg[1]; pulse_mode = cfg[2]; pulse_at_fall = cfg[3];
      if (!en)                 phase_tag = invert ? "R7 R6" : "R7";
      else if (!pulse_mode)    phase_tag = invert ? "R2 R3 R6" : "R2 R3";
      else if (!pulse_at_fall) phase_tag = invert ? "R4 R6" : "R4";
      else                     phase_tag = invert ? "R5 R6" : "R5";
      step_check(2*N + 1);
    end

    // R7: gating mid-frame must not disturb the frame phase
    invert = 1'b0; pulse_mode = 1'b1; pulse_at_fall = 1'b0;
    phase_tag = "R7 phase kept";
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); check(phase_tag);
      en = 1'b0;
      step_check(7 + k);
      en = 1'b1;
      step_check(N);
    end

    // R9 and R10: falls ignored while realignment forbidden, rises always ignored
    en = 1'b1; pulse_mode = 1'b1; pulse_at_fall = 1'b0; resync_en = 1'b0;
    phase_tag = "R9";
    for (int off = 0; off < N; off++) begin
      ext_sync = 1'b1; step_check(3);
      ext_sync = 1'b0; step_check(off + 2);
    end
    resync_en = 1'b1;
    phase_tag = "R10";
    ext_sync = 1'b0; step_check(2);
    for (int k = 0; k < 4; k++) begin
      ext_sync = 1'b1; step_check(N + k);
    end

    // R8: a fall at every count of the frame realigns it
    phase_tag = "R8";
    for (int off = 0; off < N; off++) begin
      ext_sync = 1'b1; step_check(off + 1);
      ext_sync = 1'b0; step_check(N + 3);
    end
    // R8: repeated falls in square mode with inversion
    pulse_mode = 1'b0; invert = 1'b1;
    for (int off = 0; off < 8; off++) begin
      ext_sync = 1'b1; step_check(2);
      ext_sync = 1'b0; step_check(5 + 3*off);
    end

    finish_run();
  end
endmodule